// File: doc/BRIEF.md
# Bus Address Capture and RAM Select Decoder

This block sits between an asynchronous, multiplexed address/data bus and a word-organised static RAM array. When a bus master starts a cycle by raising SYNC, the block captures the address lines and the I/O-page flag. It keeps that capture for the rest of the cycle, so a read followed by a write to the same word (read-modify-write) needs only one capture. The capture also survives the master reusing the lines for data.

The captured address drives two things. Bits 19:1 form the RAM word address. Bits 21:20 pick one of four RAM banks. Two per-bank byte-lane enables come from address bit 0 and the byte-write flag. An access that falls in the I/O page produces no selects at all. SYNC is treated as asynchronous to the system clock and passes through a synchroniser. A parameter narrows the address to 16, 18 or 22 bits for smaller systems.

Top module: `busaddr_dec`

## Requirements
- R1: While `binit_i` is high, `ram_addr_o`, `bank_en_o`, `lo_en_o` and `hi_en_o` are all zero. They stay zero after release until the next SYNC rising edge is captured.
- R2: A rising edge of `sync_i` first seen at clock edge n updates all outputs at clock edge n+3. The outputs still show the previous capture after edge n+2.
- R3: Once captured, the address and I/O-page flag hold until the next SYNC rising edge. Changes on `dal_i` or `iopage_i` while SYNC stays high, or after it falls, do not alter `ram_addr_o` or `bank_en_o`.
- R4: If `iopage_i` was high at capture, every bit of `bank_en_o`, `lo_en_o` and `hi_en_o` is zero.
- R5: For a memory access, `bank_en_o` is one-hot. Bit k is set when captured bits 21:20 equal k.
- R6: `ram_addr_o[18:0]` equals captured address bits 19:1. Bit 0 never reaches it.
- R7: With `wtbt_i` low (a read or a full-word write), `lo_en_o` and `hi_en_o` both equal `bank_en_o`.
- R8: With `wtbt_i` high (a byte write), captured bit 0 chooses the lane. 0 enables only `lo_en_o` (data bits 7:0). 1 enables only `hi_en_o` (data bits 15:8).
- R9: Byte-lane enables follow `wtbt_i` one clock later. The captured address is not touched, so a read-modify-write keeps its word and bank.
- R10: With `ADDR_W` set to 16 or 18, address bits at and above `ADDR_W` are captured as zero. Only bank 0 is selected, and the upper word-address bits read zero.
- R11: `lo_en_o` and `hi_en_o` are never set for a bank whose `bank_en_o` bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| binit_i | input | 1 | Bus initialise, active high, asynchronous clear of all state |
| sync_i | input | 1 | Bus cycle framing, asynchronous; rising edge starts a cycle |
| dal_i | input | 22 | Multiplexed address/data lines, positive logic |
| iopage_i | input | 1 | High when the address targets the I/O page |
| wtbt_i | input | 1 | High for a byte-wide write |
| ram_addr_o | output | 19 | RAM word address (captured bits 19:1) |
| bank_en_o | output | 4 | One-hot RAM bank select |
| lo_en_o | output | 4 | Per-bank low-byte enable |
| hi_en_o | output | 4 | Per-bank high-byte enable |

## Verification
The properties assume `dal_i` and `iopage_i` are stable from the SYNC rising edge until the synchronised edge has been captured. They also assume `wtbt_i` changes no more than once per clock. The stimulus meets both: it changes inputs only on falling clock edges, and it holds the address for four clocks after raising SYNC before replacing it with data-phase values. SYNC is kept low for several clocks between cycles so every rise is seen as a fresh edge. `binit_i` pulses are confined to idle bus periods.

// File: rtl/busaddr_pkg.sv
package busaddr_pkg;

    // Width of the multiplexed address/data bus
    localparam int DAL_W   = 22;
    // RAM word address covers bits 19:1
    localparam int WADDR_W = 19;
    // Bank select field sits directly above the word address
    localparam int BSEL_LO = WADDR_W + 1;
    localparam int BSEL_W  = DAL_W - BSEL_LO;
    localparam int BANK_N  = 1 << BSEL_W;

    // Captured cycle state
    typedef struct packed {
        logic             mem_ok;   // 1: memory access, 0: I/O page or nothing captured
        logic [DAL_W-1:0] addr;
    } cap_t;

    // Registered decoder outputs
    typedef struct packed {
        logic [WADDR_W-1:0] waddr;
        logic [BANK_N-1:0]  bank;
        logic [BANK_N-1:0]  lo;
        logic [BANK_N-1:0]  hi;
    } dec_t;

endpackage

// File: rtl/busaddr_sync_edge.sv
module busaddr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);

    // STAGES synchroniser flops plus one flop holding the previous stable value
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    // One-cycle strobe on a low-to-high transition of the synchronised level
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/busaddr_capture.sv
module busaddr_capture
    import busaddr_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             stb_i,
    input  logic [DAL_W-1:0] dal_i,
    input  logic             iopage_i,
    output cap_t             cap_o
);

    logic [DAL_W-1:0] dal_m;

    // Lines above the configured width are tied low for narrow systems
    generate
        for (genvar i = 0; i < DAL_W; i++) begin : g_mask
            if (i < ADDR_W) begin : g_keep
                assign dal_m[i] = dal_i[i];
            end else begin : g_zero
                assign dal_m[i] = 1'b0;
            end
        end
    endgenerate

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (stb_i) begin
            cap_d.addr   = dal_m;
            cap_d.mem_ok = ~iopage_i;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cap_o = cap_q;

endmodule

// File: rtl/busaddr_select.sv
module busaddr_select
    import busaddr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  cap_t cap_i,
    input  logic wtbt_i,
    output dec_t dec_o
);

    logic [BSEL_W-1:0] bsel;
    logic              lane_lo_ok;
    logic              lane_hi_ok;
    dec_t              dec_d, dec_q;

    assign bsel = cap_i.addr[DAL_W-1:BSEL_LO];

    // Full-word access opens both lanes; a byte write opens the lane picked by bit 0
    assign lane_lo_ok = ~wtbt_i | ~cap_i.addr[0];
    assign lane_hi_ok = ~wtbt_i |  cap_i.addr[0];

    always_comb begin
        dec_d       = '0;
        dec_d.waddr = cap_i.addr[WADDR_W:1];
        for (int b = 0; b < BANK_N; b++) begin
            dec_d.bank[b] = cap_i.mem_ok && (bsel == BSEL_W'(b));
        end
        dec_d.lo = dec_d.bank & {BANK_N{lane_lo_ok}};
        dec_d.hi = dec_d.bank & {BANK_N{lane_hi_ok}};
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_o = dec_q;

endmodule

// File: rtl/busaddr_dec.sv
module busaddr_dec
    import busaddr_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               binit_i,
    input  logic               sync_i,
    input  logic [DAL_W-1:0]   dal_i,
    input  logic               iopage_i,
    input  logic               wtbt_i,
    output logic [WADDR_W-1:0] ram_addr_o,
    output logic [BANK_N-1:0]  bank_en_o,
    output logic [BANK_N-1:0]  lo_en_o,
    output logic [BANK_N-1:0]  hi_en_o
);

    logic cap_stb;
    cap_t cap;
    dec_t dec;

    busaddr_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_i   (binit_i),
        .async_i (sync_i),
        .rise_o  (cap_stb)
    );

    busaddr_capture #(
        .ADDR_W (ADDR_W)
    ) u_cap (
        .clk_i    (clk_i),
        .rst_i    (binit_i),
        .stb_i    (cap_stb),
        .dal_i    (dal_i),
        .iopage_i (iopage_i),
        .cap_o    (cap)
    );

    busaddr_select u_sel (
        .clk_i  (clk_i),
        .rst_i  (binit_i),
        .cap_i  (cap),
        .wtbt_i (wtbt_i),
        .dec_o  (dec)
    );

    assign ram_addr_o = dec.waddr;
    assign bank_en_o  = dec.bank;
    assign lo_en_o    = dec.lo;
    assign hi_en_o    = dec.hi;

endmodule

// File: rtl/busaddr_dec_chk.sv
module busaddr_dec_chk
    import busaddr_pkg::*;
(
    input logic               clk_i,
    input logic               binit_i,
    input logic               cap_stb,
    input logic               iopage_i,
    input logic               wtbt_i,
    input logic [WADDR_W-1:0] ram_addr_o,
    input logic [BANK_N-1:0]  bank_en_o,
    input logic [BANK_N-1:0]  lo_en_o,
    input logic [BANK_N-1:0]  hi_en_o
);

    AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (binit_i)
        !cap_stb |=> ##1 $stable(ram_addr_o)); // R3

    AST_IOPAGE_VETO: assert property (@(posedge clk_i) disable iff (binit_i)
        (cap_stb && iopage_i) |=> ##1 (bank_en_o == '0 && lo_en_o == '0 && hi_en_o == '0)); // R4

    AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (binit_i)
        $onehot0(bank_en_o)); // R5

    AST_WORD_BOTH_LANES: assert property (@(posedge clk_i) disable iff (binit_i)
        !wtbt_i |=> (lo_en_o == hi_en_o)); // R7

    AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (binit_i)
        wtbt_i |=> ((lo_en_o & hi_en_o) == '0)); // R8

    AST_LANE_IN_BANK: assert property (@(posedge clk_i) disable iff (binit_i)
        ((lo_en_o | hi_en_o) & ~bank_en_o) == '0); // R11

endmodule

bind busaddr_dec busaddr_dec_chk u_chk (
    .clk_i      (clk_i),
    .binit_i    (binit_i),
    .cap_stb    (cap_stb),
    .iopage_i   (iopage_i),
    .wtbt_i     (wtbt_i),
    .ram_addr_o (ram_addr_o),
    .bank_en_o  (bank_en_o),
    .lo_en_o    (lo_en_o),
    .hi_en_o    (hi_en_o)
);

// File: tb/busaddr_dec_bench.sv
`timescale 1ns/1ps
module busaddr_dec_bench;

    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        binit;
    logic        sync;
    logic [21:0] dal;
    logic        iop;
    logic        wtbt;

    logic [18:0] waddr, waddr18, waddr16;
    logic [3:0]  bank, bank18, bank16;
    logic [3:0]  lo, lo18, lo16;
    logic [3:0]  hi, hi18, hi16;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    busaddr_dec u_busaddr_dec (
        .clk_i(clk), .binit_i(binit), .sync_i(sync), .dal_i(dal), .iopage_i(iop),
        .wtbt_i(wtbt), .ram_addr_o(waddr), .bank_en_o(bank), .lo_en_o(lo), .hi_en_o(hi));

    busaddr_dec #(.ADDR_W(18)) u_busaddr_dec_a18 (
        .clk_i(clk), .binit_i(binit), .sync_i(sync), .dal_i(dal), .iopage_i(iop),
        .wtbt_i(wtbt), .ram_addr_o(waddr18), .bank_en_o(bank18), .lo_en_o(lo18), .hi_en_o(hi18));

    busaddr_dec #(.ADDR_W(16)) u_busaddr_dec_a16 (
        .clk_i(clk), .binit_i(binit), .sync_i(sync), .dal_i(dal), .iopage_i(iop),
        .wtbt_i(wtbt), .ram_addr_o(waddr16), .bank_en_o(bank16), .lo_en_o(lo16), .hi_en_o(hi16));

    typedef struct packed {
        logic [21:0] dal;
        logic        iop;
        logic        wtbt;
        logic [3:0]  bank;
        logic [3:0]  lo;
        logic [3:0]  hi;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{22'h000000, 1'b0, 1'b0, 4'b0001, 4'b0001, 4'b0001},
        '{22'h1FFFFE, 1'b0, 1'b1, 4'b0010, 4'b0010, 4'b0000},
        '{22'h2ABCD1, 1'b0, 1'b1, 4'b0100, 4'b0000, 4'b0100},
        '{22'h3FFFFF, 1'b0, 1'b0, 4'b1000, 4'b1000, 4'b1000},
        '{22'h00E000, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000},
        '{22'h3C0001, 1'b1, 1'b1, 4'b0000, 4'b0000, 4'b0000},
        '{22'h155555, 1'b0, 1'b1, 4'b0010, 4'b0000, 4'b0010},
        '{22'h2AAAAA, 1'b0, 1'b0, 4'b0100, 4'b0100, 4'b0100}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_main(input string req, input logic [18:0] ew,
                              input logic [3:0] eb, input logic [3:0] el, input logic [3:0] eh);
        check({req, " ram_addr"}, 32'(waddr), 32'(ew));
        check({req, " bank_en"},  32'(bank),  32'(eb));
        check({req, " lo_en"},    32'(lo),    32'(el));
        check({req, " hi_en"},    32'(hi),    32'(eh));
    endtask

    // Leave SYNC low long enough for the synchroniser, then raise it with a new address
    task automatic start_cycle(input logic [21:0] a, input logic io, input logic wb);
        @(negedge clk);
        sync = 1'b0;
        repeat (4) @(negedge clk);
        dal  = a;
        iop  = io;
        wtbt = wb;
        sync = 1'b1;
    endtask

    initial begin
        #(WD_CYCLES * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        binit = 1'b1;
        sync  = 1'b0;
        dal   = 22'h3FFFFF;
        iop   = 1'b0;
        wtbt  = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        check_main("R1 reset", 19'h0, 4'h0, 4'h0, 4'h0);
        @(negedge clk);
        binit = 1'b0;
        repeat (3) @(negedge clk);
        check_main("R1 after release", 19'h0, 4'h0, 4'h0, 4'h0);

        // Table walk: R5 R6 R7 R8 R4 on capture, R3 on hold
        for (int v = 0; v < NVEC; v++) begin
            start_cycle(VECS[v].dal, VECS[v].iop, VECS[v].wtbt);
            repeat (4) @(negedge clk);
            check_main($sformatf("R5/R6/R7/R8/R4 vec%0d", v), VECS[v].dal[19:1],
                       VECS[v].bank, VECS[v].lo, VECS[v].hi);
            // data phase reuses the lines; the I/O flag also toggles
            dal = ~VECS[v].dal;
            iop = ~VECS[v].iop;
            repeat (3) @(negedge clk);
            check($sformatf("R3 hold addr vec%0d", v), 32'(waddr), 32'(VECS[v].dal[19:1]));
            check($sformatf("R3 hold bank vec%0d", v), 32'(bank),  32'(VECS[v].bank));
            sync = 1'b0;
            repeat (4) @(negedge clk);
            check($sformatf("R3 idle addr vec%0d", v), 32'(waddr), 32'(VECS[v].dal[19:1]));
            check($sformatf("R3 idle bank vec%0d", v), 32'(bank),  32'(VECS[v].bank));
        end

        // R2: latency through synchroniser, capture and decoder
        start_cycle(22'h100004, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check_main("R2 not yet", 19'h55555, 4'b0100, 4'b0100, 4'b0100);
        @(negedge clk);
        check_main("R2 updated", 19'h00002, 4'b0010, 4'b0010, 4'b0010);

        // R9: read then byte write in the same cycle, bit 0 of captured address is 0
        dal  = 22'h2AAAAB;
        wtbt = 1'b1;
        @(negedge clk);
        check_main("R9 rmw byte lane", 19'h00002, 4'b0010, 4'b0010, 4'b0000);
        wtbt = 1'b0;
        @(negedge clk);
        check_main("R9 rmw word again", 19'h00002, 4'b0010, 4'b0010, 4'b0010);

        // R10: narrow systems drop upper lines
        start_cycle(22'h3FFFFF, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check("R10 a18 addr", 32'(waddr18), 32'h1FFFF);
        check("R10 a18 bank", 32'(bank18),  32'h1);
        check("R10 a18 lanes", 32'({lo18, hi18}), 32'h11);
        check("R10 a16 addr", 32'(waddr16), 32'h7FFF);
        check("R10 a16 bank", 32'(bank16),  32'h1);
        check("R10 a16 lanes", 32'({lo16, hi16}), 32'h11);
        check_main("R10 full width", 19'h7FFFF, 4'b1000, 4'b1000, 4'b1000);

        // R1: init in mid-operation clears immediately and stays clear
        sync = 1'b0;
        repeat (4) @(negedge clk);
        binit = 1'b1;
        #1;
        check_main("R1 async clear", 19'h0, 4'h0, 4'h0, 4'h0);
        @(negedge clk);
        binit = 1'b0;
        repeat (4) @(negedge clk);
        check_main("R1 clear held", 19'h0, 4'h0, 4'h0, 4'h0);

        // R11 with R8: byte write at odd address in the top bank
        start_cycle(22'h300001, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        check_main("R11/R8 odd byte", 19'h0, 4'b1000, 4'b0000, 4'b1000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule